// File: doc/BRIEF.md
# Serial Pause-and-Resume Gate

This block sits between the pins of a serial peripheral port and the protocol engine behind it. It handles the pause function: while the chip is selected, the host can pull the pause pin low to freeze the transfer, and later release it to continue. The host can also drop the selection to abandon the transfer. The block brings the select, serial clock and pause pins into the system clock domain. It produces a registered pause flag and gated serial-clock edge strobes that drive the engine's shift and count logic. It also gates the engine's output enable and issues a one-cycle reset pulse when the transfer is abandoned during a pause.

Both entry into and exit from the pause are honoured only while the serial clock is low. A pause edge that arrives while the clock is high waits until the clock falls. While the flag is set, the engine receives no clock strobes, so its counters and shift registers keep their values and the transfer resumes exactly where it stopped. Any program or erase cycle running inside the engine is not touched by this block.

Top module: `spi_hold_ctl`

## Requirements
- R1: After synchronous reset, `hold_o`, `so_oe_o`, `sclk_rise_o`, `sclk_fall_o` and `iface_rst_o` are all 0.
- R2: A session opens only when select (`cs_n_i`) falls while the pause pin (`hold_n_i`) is high. Inside an open, unpaused session, `so_oe_o` follows `so_en_i`.
- R3: In a session, pulling `hold_n_i` low while `sclk_i` is low sets `hold_o` on the third clock edge after the pin change.
- R4: If `hold_n_i` goes low while `sclk_i` is high, `hold_o` stays 0 until `sclk_i` goes low. Further `sclk_i` changes while paused have no effect on `hold_o`.
- R5: Raising `hold_n_i` while `sclk_i` is low clears `hold_o`. If `sclk_i` is high at that time, the clear is deferred until `sclk_i` goes low.
- R6: While `hold_o` is 1, `so_oe_o` is 0 and no `sclk_rise_o` or `sclk_fall_o` strobe is issued, whatever `sclk_i` does.
- R7: If `cs_n_i` rises while paused, `iface_rst_o` pulses high for exactly one clock, `hold_o` clears and the session closes.
- R8: After a close, a `cs_n_i` fall with `hold_n_i` low does not open a session, and a later rise of `hold_n_i` alone does not open one either. A new session needs `hold_n_i` high and then a fall of `cs_n_i`.
- R9: If `cs_n_i` rises in an unpaused session, the session closes without an `iface_rst_o` pulse.
- R10: In an open, unpaused session, each `sclk_i` rising or falling edge gives exactly one one-cycle strobe on `sclk_rise_o` or `sclk_fall_o`. No strobes are issued outside a session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Select pin, active low, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| hold_n_i | input | 1 | Pause pin, active low, asynchronous |
| so_en_i | input | 1 | Output enable requested by the protocol engine |
| so_oe_o | output | 1 | Gated output enable for the data-out driver |
| sclk_rise_o | output | 1 | One-cycle strobe per qualified serial clock rising edge |
| sclk_fall_o | output | 1 | One-cycle strobe per qualified serial clock falling edge |
| hold_o | output | 1 | Pause flag, freezes the protocol engine |
| iface_rst_o | output | 1 | One-cycle reset pulse to the protocol engine |

## Verification
A wrong state in the controller shows at the ports within three clocks of the next pin change. It appears either as a pause flag that does not match the level pattern the bench applied, or as an output enable that stays high while paused. A state that wrongly admits a session after a reset close becomes visible as a raised output enable. A lost or extra strobe is found by counting strobes against the serial clock toggles applied. A missed or repeated reset pulse is found by a count taken across the whole stimulus table.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_ENTER_WAIT = 3'd2,
    ST_HOLD       = 3'd3,
    ST_EXIT_WAIT  = 3'd4
  } hold_state_e;

  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_CS   = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned PIN_W    = 3;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RST_VAL;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise[b] = lvl[b] & ~prev_q[b];
    assign fall[b] = ~lvl[b] & prev_q[b];
  end
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sclk_s,
  input  logic hold_s,
  input  logic cs_fall,
  input  logic sclk_rise,
  input  logic sclk_fall,
  input  logic so_en_i,
  output logic hold_o,
  output logic so_oe_o,
  output logic rise_o,
  output logic fall_o,
  output logic iface_rst_o
);
  hold_state_e state_q, state_d;
  logic        rst_pulse_d;

  always_comb begin
    state_d     = state_q;
    rst_pulse_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cs_fall && hold_s && !cs_s) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (cs_s)         state_d = ST_IDLE;
        else if (!hold_s) state_d = sclk_s ? ST_ENTER_WAIT : ST_HOLD;
      end
      ST_ENTER_WAIT: begin
        if (cs_s)         state_d = ST_IDLE;
        else if (hold_s)  state_d = ST_RUN;
        else if (!sclk_s) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (cs_s) begin
          state_d     = ST_IDLE;
          rst_pulse_d = 1'b1;
        end else if (hold_s) begin
          state_d = sclk_s ? ST_EXIT_WAIT : ST_RUN;
        end
      end
      ST_EXIT_WAIT: begin
        if (cs_s) begin
          state_d     = ST_IDLE;
          rst_pulse_d = 1'b1;
        end else if (!hold_s) begin
          state_d = ST_HOLD;
        end else if (!sclk_s) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      hold_o      <= 1'b0;
      so_oe_o     <= 1'b0;
      rise_o      <= 1'b0;
      fall_o      <= 1'b0;
      iface_rst_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      hold_o      <= (state_d == ST_HOLD) || (state_d == ST_EXIT_WAIT);
      so_oe_o     <= so_en_i && ((state_d == ST_RUN) || (state_d == ST_ENTER_WAIT));
      rise_o      <= sclk_rise && (state_q == ST_RUN) && (state_d == ST_RUN);
      fall_o      <= sclk_fall && (state_q == ST_RUN) && (state_d == ST_RUN);
      iface_rst_o <= rst_pulse_d;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    iface_rst_o |=> !iface_rst_o); // R7
  AST_RST_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    iface_rst_o |-> ($past(hold_o) && !hold_o)); // R7
  AST_NO_OE_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> !so_oe_o); // R6
  AST_NO_STROBE_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> !(rise_o || fall_o)); // R6
  AST_ENTRY_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_o) |-> !$past(sclk_s)); // R4
  AST_EXIT_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_o) && !iface_rst_o) |-> !$past(sclk_s)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o)); // R10
endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic hold_n_i,
  input  logic so_en_i,
  output logic so_oe_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic hold_o,
  output logic iface_rst_o
);
  localparam logic [PIN_W-1:0] PIN_IDLE = (PIN_W'(1) << PIN_CS) | (PIN_W'(1) << PIN_HOLD);

  logic [PIN_W-1:0] pins_raw, pins_s, pins_rise, pins_fall;

  assign pins_raw[PIN_SCLK] = sclk_i;
  assign pins_raw[PIN_CS]   = cs_n_i;
  assign pins_raw[PIN_HOLD] = hold_n_i;

  spi_hold_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(pins_raw), .dout(pins_s)
  );

  spi_hold_edge #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_edge (
    .clk(clk), .rst(rst), .lvl(pins_s), .rise(pins_rise), .fall(pins_fall)
  );

  spi_hold_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (pins_s[PIN_CS]),
    .sclk_s     (pins_s[PIN_SCLK]),
    .hold_s     (pins_s[PIN_HOLD]),
    .cs_fall    (pins_fall[PIN_CS]),
    .sclk_rise  (pins_rise[PIN_SCLK]),
    .sclk_fall  (pins_fall[PIN_SCLK]),
    .so_en_i    (so_en_i),
    .hold_o     (hold_o),
    .so_oe_o    (so_oe_o),
    .rise_o     (sclk_rise_o),
    .fall_o     (sclk_fall_o),
    .iface_rst_o(iface_rst_o)
  );
endmodule

// File: tb/spi_hold_ctl_tb.sv
module spi_hold_ctl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, so_en = 1'b1;
  logic so_oe, s_rise, s_fall, hold, irst;

  int checks = 0;
  int fails  = 0;
  int n_rise = 0, n_fall = 0, n_irst = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_hold_ctl u_dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .hold_n_i(hold_n),
    .so_en_i(so_en), .so_oe_o(so_oe), .sclk_rise_o(s_rise), .sclk_fall_o(s_fall),
    .hold_o(hold), .iface_rst_o(irst)
  );

  always @(negedge clk) begin
    if (!rst) begin
      n_rise <= n_rise + int'(s_rise);
      n_fall <= n_fall + int'(s_fall);
      n_irst <= n_irst + int'(irst);
    end
  end

  // {cs_n, sclk, hold_n, exp_hold, exp_oe}
  localparam int NV = 16;
  localparam logic [4:0] VEC [NV] = '{
    5'b10100, // idle                          R1
    5'b00101, // open session                  R2
    5'b00010, // pause with sclk low           R3
    5'b01010, // sclk ignored while paused     R4
    5'b01110, // release deferred, sclk high   R5
    5'b00101, // release completes            R5
    5'b01101, // sclk high in session
    5'b01001, // pause deferred, sclk high     R4
    5'b00010, // sclk low, pause takes effect  R4
    5'b00101, // release                       R5
    5'b00010, // pause again                   R3
    5'b10000, // deselect while paused         R7
    5'b00000, // cs falls with hold low        R8
    5'b00100, // hold high, no new cs fall     R8
    5'b10100, // deselect
    5'b00101  // proper restart                R8
  };
  localparam string VREQ [NV] = '{"R1","R2","R3","R4","R5","R5","R2","R4",
                                  "R4","R5","R3","R7","R8","R8","R8","R8"};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic toggle_sclk(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; step(6);
      sclk = 1'b0; step(6);
    end
  endtask

  initial begin
    int r0, f0, i0;
    step(4);
    chk("R1", "hold", hold, 0);
    chk("R1", "so_oe", so_oe, 0);
    chk("R1", "strobe", int'(s_rise | s_fall), 0);
    chk("R1", "iface_rst", irst, 0);
    rst = 1'b0;
    step(6);
    chk("R1", "hold after release", hold, 0);

    // R10: strobes outside a session
    toggle_sclk(2);
    chk("R10", "rise outside session", n_rise, 0);
    cs_n = 1'b0; step(6);
    toggle_sclk(3);
    chk("R10", "rises in session", n_rise, 3);
    chk("R10", "falls in session", n_fall, 3);
    // R6: no strobes while paused
    hold_n = 1'b0; step(6);
    chk("R3", "paused", hold, 1);
    r0 = n_rise; f0 = n_fall;
    toggle_sclk(3);
    chk("R6", "rises while paused", n_rise - r0, 0);
    chk("R6", "falls while paused", n_fall - f0, 0);
    hold_n = 1'b1; step(6);
    toggle_sclk(2);
    chk("R10", "rises after resume", n_rise - r0, 2);
    // R9: deselect without pause
    i0 = n_irst;
    cs_n = 1'b1; step(6);
    chk("R9", "no reset pulse", n_irst - i0, 0);
    chk("R9", "session closed oe", so_oe, 0);

    // table walk
    i0 = n_irst;
    for (int v = 0; v < NV; v++) begin
      cs_n = VEC[v][4]; sclk = VEC[v][3]; hold_n = VEC[v][2];
      step(6);
      chk(VREQ[v], $sformatf("vec %0d hold", v), hold, int'(VEC[v][1]));
      chk(VREQ[v], $sformatf("vec %0d so_oe", v), so_oe, int'(VEC[v][0]));
    end
    chk("R7", "reset pulses over table", n_irst - i0, 1);

    // R2: so_oe follows so_en in session
    so_en = 1'b0; step(4);
    chk("R2", "oe follows en low", so_oe, 0);
    so_en = 1'b1; step(4);
    chk("R2", "oe follows en high", so_oe, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule